// File: doc/BRIEF.md
# Raster Timing Generator, 1024x384 at 72 Hz

This block produces the scan timing for a 1024 by 384 pixel display running from a 40 MHz pixel clock. A column counter advances on every clock and a line counter advances each time a 1295-clock line completes. The block decodes both counters into active-low horizontal and vertical sync pulses and a flag that marks the visible area. It also reports pixel coordinates and gives a one-clock pulse at the close of every 428-line frame. The frame rate works out to roughly 72 Hz.

The scan starts at the top-left pixel, but the reported coordinates count from the lower-right corner. On the first visible pixel of a frame the block therefore reports the largest x and y values, and both values fall toward zero as the beam moves right and down. Sprite and collision logic downstream compare against these coordinates. A colour stage gates its output with the visible flag.

Every segment length is a parameter, so the same block can serve a smaller raster. The defaults give the mode described here.

Top module: `vga_raster_timing`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block returns to column 0, line 0. Directly after that edge, `hsync_n`=1, `vsync_n`=1, `video_active`=1, `pix_x`=1023, `pix_y`=383 and `frame_end`=0.
- R2: Columns are numbered 0 to 1294 from the start of each line. `hsync_n` is 0 for columns 1056 through 1211 and 1 for all other columns. Columns 0 to 1023 are visible and columns 1024 to 1055 are the right margin; after the pulse come 83 left-margin columns.
- R3: The line index advances only when column 1294 completes, so each line lasts 1295 clocks. The line index wraps from 427 back to 0.
- R4: `vsync_n` is 0 for the whole of lines 394 and 395 and 1 on every other line. Lines 0 to 383 are visible, lines 384 to 393 are the bottom margin, and lines 396 to 427 are the top margin.
- R5: `video_active` is 1 exactly when the column is below 1024 and the line is below 384.
- R6: While `video_active` is 1, `pix_x` = 1023 − column and `pix_y` = 383 − line. While it is 0, both coordinates read 0.
- R7: `frame_end` is 1 for a single clock, the clock of column 1294 on line 427, and is 0 at every other time. On the next clock the block is back at column 0, line 0.
- R8: The segment lengths are parameters. With reduced values (8/2/3/2 columns and 4/1/2/1 lines), R2 to R7 hold with the same segment order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| video_active | output | 1 | High inside the visible raster |
| pix_x | output | 10 | Column measured from the right edge |
| pix_y | output | 9 | Line measured from the bottom edge |
| frame_end | output | 1 | One-clock pulse on the last clock of a frame |

## Verification
The assertions check four properties on every clock:
- Both counters stay inside their periods.
- The line counter holds unless a line completes.
- A sync pulse never overlaps the visible area.
- A `frame_end` pulse is followed by a wrap to the top-left pixel, which reports the maximum coordinates.

Other behaviour can only be shown by the bench scenarios, because a checker that derived it would copy the counters. This covers the exact sync column and line positions, the mirrored coordinate values at chosen points, and the reset return in the middle of a line. A full default frame is too long for the bench, so the frame wrap and vertical sync placement are exercised on a small parameter set.

// File: rtl/vga_timing_pkg.sv
// Shared definitions for the raster timing block.
// Assumes: the segment order on each axis is visible, front margin, sync, back margin.
package vga_timing_pkg;

    typedef enum logic [1:0] {
        SEG_VISIBLE = 2'd0,
        SEG_FRONT   = 2'd1,
        SEG_SYNC    = 2'd2,
        SEG_BACK    = 2'd3
    } seg_e;

    localparam int DEF_H_VIS   = 1024;
    localparam int DEF_H_FRONT = 32;
    localparam int DEF_H_SYNC  = 156;
    localparam int DEF_H_BACK  = 83;
    localparam int DEF_V_VIS   = 384;
    localparam int DEF_V_FRONT = 10;
    localparam int DEF_V_SYNC  = 2;
    localparam int DEF_V_BACK  = 32;

endpackage

// File: rtl/vga_axis_counter.sv
// One scan axis: a wrapping counter plus a decode of which segment it is in.
// Assumes: step is a one-clock enable; every segment length is at least 1.
module vga_axis_counter
    import vga_timing_pkg::*;
#(
    parameter int VIS   = 1024,
    parameter int FRONT = 32,
    parameter int SYNC  = 156,
    parameter int BACK  = 83,
    localparam int TOTAL = VIS + FRONT + SYNC + BACK,
    localparam int W     = $clog2(TOTAL)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] cnt,
    output logic         last,
    output seg_e         seg
);

    localparam int FRONT_START = VIS;
    localparam int SYNC_START  = VIS + FRONT;
    localparam int BACK_START  = VIS + FRONT + SYNC;

    // Mark the final position of the period.
    assign last = (cnt == W'(TOTAL - 1));

    // Advance on step and wrap after the final position.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (step)
            cnt <= last ? '0 : cnt + 1'b1;
    end

    // Decode the segment from the counter value.
    always_comb begin
        if (cnt < W'(FRONT_START))
            seg = SEG_VISIBLE;
        else if (cnt < W'(SYNC_START))
            seg = SEG_FRONT;
        else if (cnt < W'(BACK_START))
            seg = SEG_SYNC;
        else
            seg = SEG_BACK;
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= W'(TOTAL - 1));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt));

    // R3
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last) |=> (cnt == '0));

endmodule

// File: rtl/vga_coord_map.sv
// Maps the raw counters to coordinates whose origin is the lower-right corner.
// Assumes: the counters lie inside the visible range whenever active is high.
module vga_coord_map #(
    parameter int VIS_W = 1024,
    parameter int VIS_H = 384,
    parameter int HW    = 11,
    parameter int VW    = 9,
    localparam int XW   = (VIS_W > 1) ? $clog2(VIS_W) : 1,
    localparam int YW   = (VIS_H > 1) ? $clog2(VIS_H) : 1
) (
    input  logic [HW-1:0] hcnt,
    input  logic [VW-1:0] vcnt,
    input  logic          active,
    output logic [XW-1:0] x,
    output logic [YW-1:0] y
);

    // Mirror both axes inside the visible area and force zero outside it.
    always_comb begin
        if (active) begin
            x = XW'(VIS_W - 1) - XW'(hcnt);
            y = YW'(VIS_H - 1) - YW'(vcnt);
        end else begin
            x = '0;
            y = '0;
        end
    end

endmodule

// File: rtl/vga_raster_timing.sv
// Top of the raster timing block. It chains a column axis to a line axis,
// decodes the active-low syncs, the visible flag and the frame-end pulse,
// and mirrors the coordinates.
// Assumes: clk is the pixel clock; rst_n is synchronous and active low.
module vga_raster_timing
    import vga_timing_pkg::*;
#(
    parameter int H_VIS   = DEF_H_VIS,
    parameter int H_FRONT = DEF_H_FRONT,
    parameter int H_SYNC  = DEF_H_SYNC,
    parameter int H_BACK  = DEF_H_BACK,
    parameter int V_VIS   = DEF_V_VIS,
    parameter int V_FRONT = DEF_V_FRONT,
    parameter int V_SYNC  = DEF_V_SYNC,
    parameter int V_BACK  = DEF_V_BACK,
    localparam int XW     = (H_VIS > 1) ? $clog2(H_VIS) : 1,
    localparam int YW     = (V_VIS > 1) ? $clog2(V_VIS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic          video_active,
    output logic [XW-1:0] pix_x,
    output logic [YW-1:0] pix_y,
    output logic          frame_end
);

    localparam int HW = $clog2(H_VIS + H_FRONT + H_SYNC + H_BACK);
    localparam int VW = $clog2(V_VIS + V_FRONT + V_SYNC + V_BACK);

    logic [HW-1:0] hcnt;
    logic [VW-1:0] vcnt;
    logic          h_last;
    logic          v_last;
    seg_e          h_seg;
    seg_e          v_seg;

    vga_axis_counter #(
        .VIS(H_VIS), .FRONT(H_FRONT), .SYNC(H_SYNC), .BACK(H_BACK)
    ) u_col (
        .clk(clk), .rst_n(rst_n), .step(1'b1),
        .cnt(hcnt), .last(h_last), .seg(h_seg)
    );

    vga_axis_counter #(
        .VIS(V_VIS), .FRONT(V_FRONT), .SYNC(V_SYNC), .BACK(V_BACK)
    ) u_line (
        .clk(clk), .rst_n(rst_n), .step(h_last),
        .cnt(vcnt), .last(v_last), .seg(v_seg)
    );

    // Decode the syncs, the visible flag and the frame-end pulse from the segments.
    always_comb begin
        hsync_n      = (h_seg != SEG_SYNC);
        vsync_n      = (v_seg != SEG_SYNC);
        video_active = (h_seg == SEG_VISIBLE) && (v_seg == SEG_VISIBLE);
        frame_end    = h_last && v_last;
    end

    vga_coord_map #(
        .VIS_W(H_VIS), .VIS_H(V_VIS), .HW(HW), .VW(VW)
    ) u_map (
        .hcnt(hcnt), .vcnt(vcnt), .active(video_active),
        .x(pix_x), .y(pix_y)
    );

    // R5
    hsync_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_n |-> !video_active);

    // R5
    vsync_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_n |-> !video_active);

    // R7
    frame_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end);

    // R7
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (video_active && pix_x == XW'(H_VIS - 1) && pix_y == YW'(V_VIS - 1)));

    // R6
    coord_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !video_active |-> (pix_x == '0 && pix_y == '0));

endmodule

// File: tb/tb_vga_raster_timing.sv
// Bench for the raster timing block. One instance uses the default mode and a
// second uses a small parameter set, so that frame-scale behaviour fits the run.
module tb_vga_raster_timing;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    int   cyc = 0;
    int   nchk = 0;
    int   nerr = 0;
    int   fe_full = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    // Count the clock edges since reset was released.
    always @(posedge clk) cyc <= run ? cyc + 1 : 0;

    logic       hs, vs, act, fe;
    logic [9:0] px;
    logic [8:0] py;
    logic       s_hs, s_vs, s_act, s_fe;
    logic [2:0] s_px;
    logic [1:0] s_py;

    vga_raster_timing dut (
        .clk(clk), .rst_n(rst_n), .hsync_n(hs), .vsync_n(vs),
        .video_active(act), .pix_x(px), .pix_y(py), .frame_end(fe)
    );

    vga_raster_timing #(
        .H_VIS(8), .H_FRONT(2), .H_SYNC(3), .H_BACK(2),
        .V_VIS(4), .V_FRONT(1), .V_SYNC(2), .V_BACK(1)
    ) dut_small (
        .clk(clk), .rst_n(rst_n), .hsync_n(s_hs), .vsync_n(s_vs),
        .video_active(s_act), .pix_x(s_px), .pix_y(s_py), .frame_end(s_fe)
    );

    // Count frame-end pulses from the default instance during the table walk.
    always @(negedge clk) if (run && fe) fe_full++;

    task automatic chk(input string req, input int act_v, input int exp_v);
        nchk++;
        if (act_v != exp_v) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act_v, exp_v, cyc);
        end
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // Stimulus vectors: line, column, hsync_n, vsync_n, active, x, y
    localparam int NV = 12;
    localparam int TV_LINE[NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 20, 39};
    localparam int TV_COL [NV] = '{0, 1023, 1024, 1055, 1056, 1211, 1212, 1294, 0, 500, 700, 1023};
    localparam int TV_HS  [NV] = '{1, 1, 1, 1, 0, 0, 1, 1, 1, 1, 1, 1};
    localparam int TV_VS  [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1};
    localparam int TV_ACT [NV] = '{1, 1, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1};
    localparam int TV_X   [NV] = '{1023, 0, 0, 0, 0, 0, 0, 0, 1023, 523, 323, 0};
    localparam int TV_Y   [NV] = '{383, 383, 0, 0, 0, 0, 0, 0, 382, 382, 363, 344};

    task automatic check_reset_state();
        chk("R1 hsync_n", int'(hs), 1);
        chk("R1 vsync_n", int'(vs), 1);
        chk("R1 active", int'(act), 1);
        chk("R1 pix_x", int'(px), 1023);
        chk("R1 pix_y", int'(py), 383);
        chk("R1 frame_end", int'(fe), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        run   = 1'b1;

        // Small instance: 15-clock lines, 8-line frames (R8)
        wait_to(10);  chk("R8 R2 small hsync low at start", int'(s_hs), 0);
        wait_to(13);  chk("R8 R2 small hsync high after", int'(s_hs), 1);
        wait_to(15);  chk("R8 R3 small line advance y", int'(s_py), 2);
        wait_to(74);  chk("R8 R4 small vsync before", int'(s_vs), 1);
        wait_to(75);  chk("R8 R4 small vsync low", int'(s_vs), 0);
        wait_to(104); chk("R8 R4 small vsync still low", int'(s_vs), 0);
        wait_to(105); chk("R8 R4 small vsync released", int'(s_vs), 1);
        wait_to(118); chk("R8 R7 small no early frame_end", int'(s_fe), 0);
        wait_to(119); chk("R8 R7 small frame_end", int'(s_fe), 1);
        wait_to(120); chk("R8 R7 small frame_end single", int'(s_fe), 0);
        chk("R8 R7 small wrap x", int'(s_px), 7);
        chk("R8 R7 small wrap y", int'(s_py), 3);
        chk("R8 R5 small active after wrap", int'(s_act), 1);
        wait_to(239); chk("R8 R7 small second frame_end", int'(s_fe), 1);

        // Mid-line reset returns to scan start (R1)
        wait_to(700);
        rst_n = 1'b0;
        run   = 1'b0;
        @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        run   = 1'b1;
        fe_full = 0;

        // Default instance: walk the vector table
        for (int i = 0; i < NV; i++) begin
            wait_to(TV_LINE[i] * 1295 + TV_COL[i]);
            chk("R2 hsync_n", int'(hs), TV_HS[i]);
            chk("R4 vsync_n", int'(vs), TV_VS[i]);
            chk("R5 video_active", int'(act), TV_ACT[i]);
            chk("R6 pix_x", int'(px), TV_X[i]);
            chk("R6 pix_y", int'(py), TV_Y[i]);
        end
        chk("R3 R7 no frame_end inside first lines", fe_full, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

endmodule